// File: doc/BRIEF.md
# Split-width event counter bank with staged writes

The block holds four 32-bit event counters behind a small register bus. Each physical counter can run whole, or it can be split into two independent 16-bit halves. The split gives eight logical counters in total. Each logical counter takes its own single-cycle event pulse, counts it while the unit is enabled, and records a wrap in a sticky status bit. An interrupt line is raised while any status bit whose per-counter interrupt enable is set remains set.

Software never loads a counter directly. A bus write to a physical counter only fills a holding latch for that counter and marks it as pending. Later, a write to the global control register with the enable bit set copies every pending latch into its live counter in a single cycle. This also happens when the unit is already running, so a control rewrite is the way to make staged values take effect. Reads always return the live count.

Every register is 32 bits wide and travels in the upper half of a 64-bit bus word. Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `perf_ctr_bank`

## Requirements
- R1: In whole mode, physical counter p (word address 0x00+p, p in 0..3) adds one for each cycle in which event input p is high while enabled, and wraps from 0xFFFFFFFF to 0. Event inputs 4..7 have no effect on a whole-mode counter.
- R2: The control register (word address 0x18) holds the global enable in bit 31 and the split flag of physical counter p in bit p. It reads back as written in those bits and reads zero elsewhere. In split mode, bits 31:16 count event p, bits 15:0 count event p+4, and no carry passes between the halves.
- R3: Logical counter n is read at word address 0x08+n and maps to physical counter n mod 4. For a split counter, n<4 returns the upper half and n>=4 returns the lower half, zero-extended. For a whole counter, n<4 returns the full 32 bits and n>=4 returns the lower 16 bits.
- R4: Register data sits in bus bits 63:32. Write data in bits 31:0 is ignored, and read data bits 31:0 are always zero.
- R5: A write to a physical counter address changes only that counter's latch. The live count, as read back, stays unchanged until a commit.
- R6: Any control write with bit 31 set loads every pending latch into its live counter and clears the pending mark. This holds even when the unit is already enabled. Counters with no pending latch are not reloaded.
- R7: While the global enable is clear, the live counters hold their values and ignore all events.
- R8: The status register (word address 0x19) has one sticky bit per logical counter. A wrap of the upper half or of a whole counter p sets bit p, and a wrap of a lower half sets bit p+4. The bit is visible on the cycle after the counting edge.
- R9: Writing the status register with a 1 in a bit position clears that bit. Bits written with 0 are left unchanged.
- R10: The per-counter control register of logical counter n (word address 0x10+n) holds an interrupt enable in bit 0 and reads it back. The interrupt output is high while any status bit is set together with its enable.
- R11: Reads of unused addresses (0x04..0x07 and 0x1A..0x1F) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register word address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 64 | Write data; the register value is in bits 63:32 |
| bus_rdata | output | 64 | Combinational read data; the register value is in bits 63:32 |
| evt_i | input | 8 | One event pulse per logical counter |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Bus writes, event pulses and commits are all sampled at one rising edge, and their results (latch contents, live counts, status bits and the interrupt) become readable on the next cycle. Read data is combinational from the address. The bench therefore drives every stimulus for exactly one cycle from the falling edge. It sets the read address on the following falling edge and samples it a short delay later, so each check lands one edge after its cause. Wrap checks preload counters one step below the limit through the latch and commit path, so the overflow cycle is known exactly.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;
  localparam int NPHYS   = 4;
  localparam int NLOG    = 2 * NPHYS;
  localparam int ADDR_W  = 5;
  localparam int PIDX_W  = $clog2(NPHYS);
  localparam int LIDX_W  = $clog2(NLOG);
  localparam int EN_BIT  = 31;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 5'h18;
  localparam logic [ADDR_W-1:0] ADR_STS  = 5'h19;

  // region decode on upper address bits
  function automatic logic is_phys(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PIDX_W] == '0;
  endfunction

  function automatic logic is_log(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LIDX_W] == 2'b01;
  endfunction

  function automatic logic is_cctl(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LIDX_W] == 2'b10;
  endfunction
endpackage

// File: rtl/pc_phys_slice.sv
module pc_phys_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         split_i,
  input  logic         commit_i,
  input  logic         lat_we_i,
  input  logic [W-1:0] lat_data_i,
  input  logic         evt_hi_i,
  input  logic         evt_lo_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_hi_o,
  output logic         wrap_lo_o
);
  localparam int HW = W / 2;

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] latch_q, latch_d;
  logic         pend_q, pend_d;

  always_comb begin
    cnt_d     = cnt_q;
    latch_d   = latch_q;
    pend_d    = pend_q;
    wrap_hi_o = 1'b0;
    wrap_lo_o = 1'b0;
    if (lat_we_i) begin
      latch_d = lat_data_i;
      pend_d  = 1'b1;
    end
    if (commit_i && pend_q) begin
      cnt_d  = latch_q;
      pend_d = 1'b0;
    end else if (run_i) begin
      if (split_i) begin
        if (evt_hi_i) begin
          cnt_d[W-1:HW] = cnt_q[W-1:HW] + HW'(1);
          wrap_hi_o     = &cnt_q[W-1:HW];
        end
        if (evt_lo_i) begin
          cnt_d[HW-1:0] = cnt_q[HW-1:0] + HW'(1);
          wrap_lo_o     = &cnt_q[HW-1:0];
        end
      end else if (evt_hi_i) begin
        cnt_d     = cnt_q + W'(1);
        wrap_hi_o = &cnt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      latch_q <= latch_d;
      pend_q  <= pend_d;
    end
  end

  assign cnt_o = cnt_q;

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !commit_i) |=> $stable(cnt_q));

  // R6
  commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && pend_q) |=> (cnt_q == $past(latch_q)));
endmodule

// File: rtl/pc_status.sv
module pc_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q, sts_d;

  // a wrap in the same cycle as a clear wins
  always_comb sts_d = (sts_q & ~clr_i) | wrap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ie_i);

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_i) |=> ((sts_q & $past(wrap_i)) == $past(wrap_i)));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
endmodule

// File: rtl/pc_rd_mux.sv
module pc_rd_mux
  import perf_ctr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NPHYS-1:0][W-1:0]  cnt_i,
  input  logic [NPHYS-1:0]         split_i,
  input  logic                     en_i,
  input  logic [NLOG-1:0]          ie_i,
  input  logic [NLOG-1:0]          sts_i,
  output logic [W-1:0]             rd_o
);
  localparam int HW = W / 2;

  logic [PIDX_W-1:0] pidx;
  logic              upper;
  logic [W-1:0]      sel;

  assign pidx  = addr_i[PIDX_W-1:0];
  assign upper = ~addr_i[PIDX_W];
  assign sel   = cnt_i[pidx];

  always_comb begin
    rd_o = '0;
    if (is_phys(addr_i)) begin
      rd_o = sel;
    end else if (is_log(addr_i)) begin
      if (upper && !split_i[pidx]) rd_o = sel;
      else if (upper)              rd_o = {{HW{1'b0}}, sel[W-1:HW]};
      else                         rd_o = {{HW{1'b0}}, sel[HW-1:0]};
    end else if (is_cctl(addr_i)) begin
      rd_o = {{(W-1){1'b0}}, ie_i[addr_i[LIDX_W-1:0]]};
    end else if (addr_i == ADR_CTRL) begin
      rd_o = {en_i, {(W-1-NPHYS){1'b0}}, split_i};
    end else if (addr_i == ADR_STS) begin
      rd_o = {{(W-NLOG){1'b0}}, sts_i};
    end
  end
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_ctr_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NLOG-1:0]   evt_i,
  output logic              irq_o
);
  localparam int REG_W = BUS_W / 2;

  logic [REG_W-1:0]           wr_word;
  logic                       en_q, en_d;
  logic [NPHYS-1:0]           split_q, split_d;
  logic [NLOG-1:0]            ie_q, ie_d;
  logic                       ctrl_we, commit;
  logic [NLOG-1:0]            sts_clr, sts, wraps;
  logic [NPHYS-1:0][REG_W-1:0] cnt;
  logic [REG_W-1:0]           rd_word;

  assign wr_word = bus_wdata[BUS_W-1:REG_W];
  assign ctrl_we = bus_we && (bus_addr == ADR_CTRL);
  assign commit  = ctrl_we && wr_word[EN_BIT];
  assign sts_clr = (bus_we && bus_addr == ADR_STS) ? wr_word[NLOG-1:0] : '0;

  always_comb begin
    en_d    = en_q;
    split_d = split_q;
    ie_d    = ie_q;
    if (ctrl_we) begin
      en_d    = wr_word[EN_BIT];
      split_d = wr_word[NPHYS-1:0];
    end
    if (bus_we && is_cctl(bus_addr)) ie_d[bus_addr[LIDX_W-1:0]] = wr_word[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      split_q <= '0;
      ie_q    <= '0;
    end else begin
      en_q    <= en_d;
      split_q <= split_d;
      ie_q    <= ie_d;
    end
  end

  for (genvar p = 0; p < NPHYS; p++) begin : g_slice
    logic lat_we;
    assign lat_we = bus_we && is_phys(bus_addr) && (bus_addr[PIDX_W-1:0] == PIDX_W'(p));
    pc_phys_slice #(.W(REG_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (en_q),
      .split_i   (split_q[p]),
      .commit_i  (commit),
      .lat_we_i  (lat_we),
      .lat_data_i(wr_word),
      .evt_hi_i  (evt_i[p]),
      .evt_lo_i  (evt_i[p+NPHYS]),
      .cnt_o     (cnt[p]),
      .wrap_hi_o (wraps[p]),
      .wrap_lo_o (wraps[p+NPHYS])
    );
  end

  pc_status #(.N(NLOG)) u_status (
    .clk  (clk),
    .rst_n(rst_n),
    .wrap_i(wraps),
    .clr_i(sts_clr),
    .ie_i (ie_q),
    .sts_o(sts),
    .irq_o(irq_o)
  );

  pc_rd_mux #(.W(REG_W)) u_rd (
    .addr_i (bus_addr),
    .cnt_i  (cnt),
    .split_i(split_q),
    .en_i   (en_q),
    .ie_i   (ie_q),
    .sts_i  (sts),
    .rd_o   (rd_word)
  );

  assign bus_rdata = {rd_word, {REG_W{1'b0}}};

  // R4
  low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[REG_W-1:0] == '0);
endmodule

// File: tb/perf_ctr_bank_test.sv
module perf_ctr_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic [7:0]  evt_i;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  perf_ctr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = {d, 32'hDEAD_BEEF};
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata[63:32];
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    evt_i = m;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic rchk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, $sformatf("addr %h", a), {32'h0, v}, {32'h0, exp});
  endtask

  task automatic t_reset;
    rd(5'h18, bus_wdata[63:32]);
    bus_wdata = '0;
    @(negedge clk);
    bus_addr = 5'h18; #1;
    chk("R4", "ctrl word after reset", bus_rdata, 64'h0);
    rchk("R1", 5'h00, 32'h0);
    rchk("R8", 5'h19, 32'h0);
    chk("R10", "irq after reset", {63'h0, irq_o}, 64'h0);
  endtask

  task automatic t_latch;
    wr(5'h00, 32'h0000_0100);
    rchk("R5", 5'h00, 32'h0);
    pulse(8'h01);
    rchk("R7", 5'h00, 32'h0);
    wr(5'h18, 32'h8000_0000);
    rchk("R6", 5'h00, 32'h0000_0100);
    @(negedge clk);
    bus_addr = 5'h00; #1;
    chk("R4", "low half on read", {32'h0, bus_rdata[31:0]}, 64'h0);
    rchk("R2", 5'h18, 32'h8000_0000);
  endtask

  task automatic t_count32;
    for (int i = 0; i < 3; i++) pulse(8'h01);
    rchk("R1", 5'h00, 32'h0000_0103);
    pulse(8'h10);
    rchk("R1", 5'h00, 32'h0000_0103);
  endtask

  task automatic t_commit_running;
    wr(5'h01, 32'h0000_0055);
    rchk("R5", 5'h01, 32'h0);
    wr(5'h18, 32'h8000_0000);
    rchk("R6", 5'h01, 32'h0000_0055);
    rchk("R6", 5'h00, 32'h0000_0103);
    pulse(8'h02);
    wr(5'h18, 32'h8000_0000);
    rchk("R6", 5'h01, 32'h0000_0056);
  endtask

  task automatic t_split;
    wr(5'h18, 32'h8000_0004);
    wr(5'h02, 32'h0005_FFFE);
    wr(5'h18, 32'h8000_0004);
    rchk("R6", 5'h02, 32'h0005_FFFE);
    pulse(8'h04);
    rchk("R2", 5'h02, 32'h0006_FFFE);
    pulse(8'h40);
    rchk("R2", 5'h02, 32'h0006_FFFF);
    rchk("R8", 5'h19, 32'h0);
    pulse(8'h40);
    rchk("R2", 5'h02, 32'h0006_0000);
    rchk("R8", 5'h19, 32'h0000_0040);
    rchk("R3", 5'h0A, 32'h0000_0006);
    rchk("R3", 5'h0E, 32'h0000_0000);
    chk("R10", "irq without enable", {63'h0, irq_o}, 64'h0);
    wr(5'h16, 32'h1);
    rchk("R10", 5'h16, 32'h1);
    chk("R10", "irq with enable", {63'h0, irq_o}, 64'h1);
    wr(5'h19, 32'h40);
    rchk("R9", 5'h19, 32'h0);
    chk("R10", "irq after clear", {63'h0, irq_o}, 64'h0);
    pulse(8'h44);
    rchk("R2", 5'h02, 32'h0007_0001);
  endtask

  task automatic t_wrap32;
    wr(5'h03, 32'hFFFF_FFFF);
    wr(5'h18, 32'h8000_0004);
    rchk("R3", 5'h0B, 32'hFFFF_FFFF);
    rchk("R3", 5'h0F, 32'h0000_FFFF);
    pulse(8'h08);
    rchk("R1", 5'h03, 32'h0);
    rchk("R8", 5'h19, 32'h0000_0008);
    wr(5'h19, 32'h1);
    rchk("R9", 5'h19, 32'h0000_0008);
    wr(5'h19, 32'h8);
    rchk("R9", 5'h19, 32'h0);
  endtask

  task automatic t_disable;
    wr(5'h18, 32'h0000_0004);
    pulse(8'hFF);
    rchk("R7", 5'h00, 32'h0000_0103);
    rchk("R7", 5'h02, 32'h0007_0001);
  endtask

  task automatic t_unmapped;
    rchk("R11", 5'h1C, 32'h0);
    rchk("R11", 5'h05, 32'h0);
    wr(5'h1C, 32'hFFFF_FFFF);
    rchk("R11", 5'h18, 32'h0000_0004);
    rchk("R11", 5'h1C, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_count32();
    t_commit_running();
    t_split();
    t_wrap32();
    t_disable();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule